// File: doc/BRIEF.md
# Register-File ALU Execution Core

This block is the execute stage of a small 8-bit core. Thirty-two general registers feed a single shared ALU. On each cycle where the start strobe is high and the core is not busy, the opcode picks the operation. Two source indices choose the operands, and a destination index chooses where the result goes. The result is written back, and the five status flags are updated, on the same clock edge.

Add, subtract, increment, AND, OR and NOT all finish in one clock. The unsigned 8x8 multiply takes two clocks. At its start edge it captures the operands and raises `busy` for one cycle. At the next edge it writes the 16-bit product into registers 1 (high byte) and 0 (low byte).

A combinational debug port returns the contents of any register. Fetch, memory access and branching belong to the surrounding pipeline.

Top module: `rf_alu_core`

## Requirements
- R1: A synchronous reset clears all 32 registers and all five flags to zero.
- R2: An operation is accepted when `start` is high, `busy` is low and the opcode is not 6 or 7. It reads registers `srcA` and `srcB` and writes its 8-bit result to register `dstIdx` at that clock edge. Opcode encoding: 0 add (A+B), 1 subtract (A-B), 2 increment (A+1), 3 AND, 4 OR, 5 NOT (~A), 6 multiply, 7 reserved.
- R3: For add and subtract, `flags[0]` (C) is the carry or borrow out of bit 7, `flags[4]` (H) is the carry or borrow out of bit 3, and `flags[3]` (V) is the two's-complement overflow.
- R4: Every accepted non-multiply operation sets `flags[1]` (Z) when its 8-bit result is zero, and sets `flags[2]` (N) to result bit 7. All flags update on the same edge as the write-back.
- R5: Increment keeps C unchanged. It sets H to the carry out of bit 3 and sets V when the operand was 0x7F.
- R6: AND, OR and NOT clear V and keep C and H unchanged.
- R7: Multiply (opcode 6) forms the unsigned product of registers `srcA` and `srcB` as read at its start edge. It writes the product to registers 1:0 one clock later. C becomes product bit 15 and Z is set when the whole product is zero. N, V and H are kept, and no register changes at the start edge.
- R8: `busy` is high for exactly the one cycle that follows an accepted multiply start.
- R9: A `start` that arrives while `busy` is high is ignored, so no register other than 1:0 and no flag other than C and Z changes.
- R10: When a source index equals the destination index, the operand is the register's value from before that cycle's write.
- R11: `dbgData` shows register `dbgIdx` combinationally, with no clock needed.
- R12: With `start` low, or with opcode 7, no register or flag changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opCode | input | 3 | Operation select (encoding in R2) |
| srcA | input | 5 | First source register index |
| srcB | input | 5 | Second source register index |
| dstIdx | input | 5 | Destination register index |
| start | input | 1 | Issue strobe |
| busy | output | 1 | High during the second multiply cycle |
| flags | output | 5 | {H, V, N, Z, C} from bit 4 down to bit 0 |
| dbgIdx | input | 5 | Debug read index |
| dbgData | output | 8 | Debug read data |

## Verification
The assertions watch several properties on every cycle. They check that each write lands in the addressed register one edge later and that the product lands in the register pair. They check that `busy` never lasts longer than one cycle, and that flags stay frozen during the busy cycle. They also check that logical operations and increment keep the carry, and that the multiply keeps N, V and H.

The arithmetic flag values need the bench's scenarios. These include half-carry and overflow on specific operands, and borrow on subtraction. Other cases also need concrete stimulus to show: same-index read-before-write chains, ignored strobes during `busy`, reserved opcodes, and the reset clearing a register file that already holds data.

// File: rtl/rf_alu_pkg.sv
package rf_alu_pkg;

  localparam int DATA_W = 8;
  localparam int NREG   = 32;
  localparam int FLAG_W = 5;

  localparam int FLG_C = 0;
  localparam int FLG_Z = 1;
  localparam int FLG_N = 2;
  localparam int FLG_V = 3;
  localparam int FLG_H = 4;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_INC = 3'd2,
    OP_AND = 3'd3,
    OP_OR  = 3'd4,
    OP_NOT = 3'd5,
    OP_MUL = 3'd6,
    OP_RSV = 3'd7
  } aluOp_t;

  // strobes from control to datapath
  typedef struct packed {
    logic aluWr;     // single-cycle result and flag write
    logic mulLatch;  // capture multiply operands
    logic mulWr;     // write product pair and C/Z
  } ctrlStrb_t;

endpackage

// File: rtl/rf_alu_ctrl.sv
module rf_alu_ctrl
  import rf_alu_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [2:0] opCode,
  output ctrlStrb_t  strb,
  output logic       busy
);

  aluOp_t op;
  logic   mulPend;
  logic   accept;

  assign op     = aluOp_t'(opCode);
  assign accept = start && !mulPend;

  always_ff @(posedge clk) begin
    if (rst) begin
      mulPend <= 1'b0;
    end else if (mulPend) begin
      mulPend <= 1'b0;
    end else if (start && op == OP_MUL) begin
      mulPend <= 1'b1;
    end
  end

  always_comb begin
    strb          = '0;
    strb.aluWr    = accept && (op != OP_MUL) && (op != OP_RSV);
    strb.mulLatch = accept && (op == OP_MUL);
    strb.mulWr    = mulPend;
  end

  assign busy = mulPend;

  // R8: busy lasts one cycle only
  a_r8_busy_single: assert property (@(posedge clk) disable iff (rst)
    busy |=> !busy);

  // R8: an accepted multiply raises busy for the next cycle
  a_r8_mul_raises_busy: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && opCode == 3'd6) |=> busy);

  // R9: nothing is issued while busy
  a_r9_no_issue_busy: assert property (@(posedge clk) disable iff (rst)
    busy |-> !(strb.aluWr || strb.mulLatch));

endmodule

// File: rtl/rf_alu_regfile.sv
module rf_alu_regfile #(
  parameter int DATA_W = 8,
  parameter int NREG   = 32,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  rdIdxA,
  input  logic [IDX_W-1:0]  rdIdxB,
  input  logic [IDX_W-1:0]  dbgIdx,
  output logic [DATA_W-1:0] rdA,
  output logic [DATA_W-1:0] rdB,
  output logic [DATA_W-1:0] dbgQ,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [DATA_W-1:0] wrData,
  input  logic              pairEn,
  input  logic [DATA_W-1:0] pairLo,
  input  logic [DATA_W-1:0] pairHi
);

  logic [DATA_W-1:0] mem   [NREG];
  logic [DATA_W-1:0] wordD [NREG];
  logic [NREG-1:0]   wordEn;

  // per-register write select; pair writes go to registers 0 and 1
  for (genvar g = 0; g < NREG; g++) begin : g_word
    if (g == 0) begin : g_lo
      assign wordEn[g] = pairEn || (wrEn && wrIdx == IDX_W'(g));
      assign wordD[g]  = pairEn ? pairLo : wrData;
    end else if (g == 1) begin : g_hi
      assign wordEn[g] = pairEn || (wrEn && wrIdx == IDX_W'(g));
      assign wordD[g]  = pairEn ? pairHi : wrData;
    end else begin : g_gen
      assign wordEn[g] = wrEn && wrIdx == IDX_W'(g);
      assign wordD[g]  = wrData;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NREG; i++) begin
      if (rst) begin
        mem[i] <= '0;
      end else if (wordEn[i]) begin
        mem[i] <= wordD[i];
      end
    end
  end

  // reads see the value held before this cycle's write
  assign rdA  = mem[rdIdxA];
  assign rdB  = mem[rdIdxB];
  assign dbgQ = mem[dbgIdx];

  // R2: addressed register holds the written value after the edge
  a_r2_writeback: assert property (@(posedge clk) disable iff (rst)
    wrEn |=> mem[$past(wrIdx)] == $past(wrData));

  // R7: product pair lands in registers 1:0
  a_r7_pair_write: assert property (@(posedge clk) disable iff (rst)
    pairEn |=> (mem[0] == $past(pairLo)) && (mem[1] == $past(pairHi)));

  // R1: reset clears the boundary registers
  a_r1_reset_regs: assert property (@(posedge clk)
    rst |=> (mem[0] == '0) && (mem[NREG-1] == '0));

endmodule

// File: rtl/rf_alu_dpath.sv
module rf_alu_dpath
  import rf_alu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int NREG   = 32,
  localparam int IDX_W = $clog2(NREG),
  localparam int HALF  = DATA_W / 2,
  localparam int MSB   = DATA_W - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrlStrb_t         strb,
  input  logic [2:0]        opCode,
  input  logic [IDX_W-1:0]  srcA,
  input  logic [IDX_W-1:0]  srcB,
  input  logic [IDX_W-1:0]  dstIdx,
  input  logic [IDX_W-1:0]  dbgIdx,
  output logic [DATA_W-1:0] dbgData,
  output logic [FLAG_W-1:0] flags
);

  aluOp_t              op;
  logic [DATA_W-1:0]   opA, opB;
  logic [DATA_W-1:0]   aluRes;
  logic [DATA_W:0]     wide;
  logic [HALF:0]       nib;
  logic [FLAG_W-1:0]   flagQ, aluFlags;
  logic [DATA_W-1:0]   mulA, mulB;
  logic [2*DATA_W-1:0] product;

  assign op = aluOp_t'(opCode);

  rf_alu_regfile #(.DATA_W(DATA_W), .NREG(NREG)) u_rf (
    .clk    (clk),
    .rst    (rst),
    .rdIdxA (srcA),
    .rdIdxB (srcB),
    .dbgIdx (dbgIdx),
    .rdA    (opA),
    .rdB    (opB),
    .dbgQ   (dbgData),
    .wrEn   (strb.aluWr),
    .wrIdx  (dstIdx),
    .wrData (aluRes),
    .pairEn (strb.mulWr),
    .pairLo (product[DATA_W-1:0]),
    .pairHi (product[2*DATA_W-1:DATA_W])
  );

  // single-cycle ALU
  always_comb begin
    wide     = '0;
    nib      = '0;
    aluRes   = '0;
    aluFlags = flagQ;
    unique case (op)
      OP_ADD: begin
        wide   = {1'b0, opA} + {1'b0, opB};
        nib    = {1'b0, opA[HALF-1:0]} + {1'b0, opB[HALF-1:0]};
        aluRes = wide[DATA_W-1:0];
        aluFlags[FLG_C] = wide[DATA_W];
        aluFlags[FLG_H] = nib[HALF];
        aluFlags[FLG_V] = (opA[MSB] == opB[MSB]) && (aluRes[MSB] != opA[MSB]);
      end
      OP_SUB: begin
        wide   = {1'b0, opA} - {1'b0, opB};
        nib    = {1'b0, opA[HALF-1:0]} - {1'b0, opB[HALF-1:0]};
        aluRes = wide[DATA_W-1:0];
        aluFlags[FLG_C] = wide[DATA_W];
        aluFlags[FLG_H] = nib[HALF];
        aluFlags[FLG_V] = (opA[MSB] != opB[MSB]) && (aluRes[MSB] != opA[MSB]);
      end
      OP_INC: begin
        nib    = {1'b0, opA[HALF-1:0]} + {{HALF{1'b0}}, 1'b1};
        aluRes = opA + {{(DATA_W-1){1'b0}}, 1'b1};
        aluFlags[FLG_H] = nib[HALF];
        aluFlags[FLG_V] = aluRes[MSB] && !opA[MSB];
      end
      OP_AND: begin
        aluRes = opA & opB;
        aluFlags[FLG_V] = 1'b0;
      end
      OP_OR: begin
        aluRes = opA | opB;
        aluFlags[FLG_V] = 1'b0;
      end
      OP_NOT: begin
        aluRes = ~opA;
        aluFlags[FLG_V] = 1'b0;
      end
      default: begin
        aluRes = '0;
      end
    endcase
    aluFlags[FLG_Z] = (aluRes == '0);
    aluFlags[FLG_N] = aluRes[MSB];
  end

  // two-cycle multiply: operands captured, product written next edge
  always_ff @(posedge clk) begin
    if (rst) begin
      mulA <= '0;
      mulB <= '0;
    end else if (strb.mulLatch) begin
      mulA <= opA;
      mulB <= opB;
    end
  end

  assign product = mulA * mulB;

  always_ff @(posedge clk) begin
    if (rst) begin
      flagQ <= '0;
    end else if (strb.mulWr) begin
      flagQ[FLG_C] <= product[2*DATA_W-1];
      flagQ[FLG_Z] <= (product == '0);
    end else if (strb.aluWr) begin
      flagQ <= aluFlags;
    end
  end

  assign flags = flagQ;

  // R6: logical operations clear V, keep C and H
  a_r6_logic_flags: assert property (@(posedge clk) disable iff (rst)
    (strb.aluWr && (opCode == 3'd3 || opCode == 3'd4 || opCode == 3'd5))
    |=> !flagQ[FLG_V] && flagQ[FLG_C] == $past(flagQ[FLG_C])
        && flagQ[FLG_H] == $past(flagQ[FLG_H]));

  // R5: increment keeps carry
  a_r5_inc_keeps_c: assert property (@(posedge clk) disable iff (rst)
    (strb.aluWr && opCode == 3'd2) |=> flagQ[FLG_C] == $past(flagQ[FLG_C]));

  // R7: multiply leaves N, V and H alone
  a_r7_mul_keeps_nvh: assert property (@(posedge clk) disable iff (rst)
    strb.mulWr |=> $stable(flagQ[FLG_H:FLG_N]));

  // R9: flags frozen across the busy cycle
  a_r9_flags_frozen: assert property (@(posedge clk) disable iff (rst)
    strb.mulLatch |=> $stable(flagQ));

  // R1: reset clears flags
  a_r1_reset_flags: assert property (@(posedge clk)
    rst |=> flagQ == '0);

endmodule

// File: rtl/rf_alu_core.sv
module rf_alu_core
  import rf_alu_pkg::*;
#(
  parameter int DATA_W = rf_alu_pkg::DATA_W,
  parameter int NREG   = rf_alu_pkg::NREG,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        opCode,
  input  logic [IDX_W-1:0]  srcA,
  input  logic [IDX_W-1:0]  srcB,
  input  logic [IDX_W-1:0]  dstIdx,
  input  logic              start,
  output logic              busy,
  output logic [FLAG_W-1:0] flags,
  input  logic [IDX_W-1:0]  dbgIdx,
  output logic [DATA_W-1:0] dbgData
);

  ctrlStrb_t strb;

  rf_alu_ctrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .opCode (opCode),
    .strb   (strb),
    .busy   (busy)
  );

  rf_alu_dpath #(.DATA_W(DATA_W), .NREG(NREG)) u_dpath (
    .clk     (clk),
    .rst     (rst),
    .strb    (strb),
    .opCode  (opCode),
    .srcA    (srcA),
    .srcB    (srcB),
    .dstIdx  (dstIdx),
    .dbgIdx  (dbgIdx),
    .dbgData (dbgData),
    .flags   (flags)
  );

endmodule

// File: tb/rf_alu_core_tb.sv
`timescale 1ns/1ps
module rf_alu_core_tb;

  logic       clk = 1'b0;
  logic       rst;
  logic [2:0] opCode;
  logic [4:0] srcA, srcB, dstIdx, dbgIdx;
  logic       start;
  logic       busy;
  logic [4:0] flags;
  logic [7:0] dbgData;

  always #4 clk = ~clk;  // 125 MHz

  rf_alu_core u_dut (
    .clk(clk), .rst(rst), .opCode(opCode), .srcA(srcA), .srcB(srcB),
    .dstIdx(dstIdx), .start(start), .busy(busy), .flags(flags),
    .dbgIdx(dbgIdx), .dbgData(dbgData)
  );

  int nChk = 0;
  int nBad = 0;
  logic [7:0] mReg [32];
  logic [4:0] mFlg;  // {H,V,N,Z,C}

  // {op, a, b, d, expected result}
  localparam int NVEC = 20;
  localparam logic [25:0] VEC [NVEC] = '{
    {3'd5, 5'd0,  5'd0,  5'd2,  8'hFF},
    {3'd2, 5'd0,  5'd0,  5'd3,  8'h01},
    {3'd0, 5'd3,  5'd3,  5'd6,  8'h02},
    {3'd0, 5'd6,  5'd6,  5'd6,  8'h04},
    {3'd0, 5'd6,  5'd6,  5'd6,  8'h08},
    {3'd0, 5'd6,  5'd6,  5'd6,  8'h10},
    {3'd0, 5'd6,  5'd6,  5'd6,  8'h20},
    {3'd0, 5'd6,  5'd6,  5'd6,  8'h40},
    {3'd0, 5'd6,  5'd6,  5'd6,  8'h80},
    {3'd5, 5'd6,  5'd0,  5'd7,  8'h7F},
    {3'd2, 5'd7,  5'd0,  5'd8,  8'h80},
    {3'd0, 5'd2,  5'd3,  5'd9,  8'h00},
    {3'd1, 5'd3,  5'd2,  5'd10, 8'h02},
    {3'd1, 5'd6,  5'd3,  5'd11, 8'h7F},
    {3'd3, 5'd2,  5'd7,  5'd12, 8'h7F},
    {3'd4, 5'd6,  5'd3,  5'd13, 8'h81},
    {3'd3, 5'd6,  5'd7,  5'd14, 8'h00},
    {3'd2, 5'd2,  5'd0,  5'd15, 8'h00},
    {3'd1, 5'd3,  5'd3,  5'd16, 8'h00},
    {3'd4, 5'd0,  5'd0,  5'd17, 8'h00}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic peek(input logic [4:0] idx, output logic [7:0] val);
    dbgIdx = idx;
    #1;
    val = dbgData;
  endtask

  // reference behaviour from the requirements
  task automatic modelOp(input logic [2:0] op, input logic [4:0] a,
                         input logic [4:0] b, input logic [4:0] d);
    logic [7:0] x, y, r;
    logic [8:0] w;
    logic [4:0] h;
    x = mReg[a];
    y = mReg[b];
    r = 8'h00;
    case (op)
      3'd0: begin
        w = {1'b0, x} + {1'b0, y}; h = {1'b0, x[3:0]} + {1'b0, y[3:0]};
        r = w[7:0]; mFlg[0] = w[8]; mFlg[4] = h[4];
        mFlg[3] = (x[7] == y[7]) && (r[7] != x[7]);
      end
      3'd1: begin
        w = {1'b0, x} - {1'b0, y}; h = {1'b0, x[3:0]} - {1'b0, y[3:0]};
        r = w[7:0]; mFlg[0] = w[8]; mFlg[4] = h[4];
        mFlg[3] = (x[7] != y[7]) && (r[7] != x[7]);
      end
      3'd2: begin
        r = x + 8'd1; mFlg[4] = (x[3:0] == 4'hF); mFlg[3] = (x == 8'h7F);
      end
      3'd3: begin r = x & y; mFlg[3] = 1'b0; end
      3'd4: begin r = x | y; mFlg[3] = 1'b0; end
      default: begin r = ~x; mFlg[3] = 1'b0; end
    endcase
    mFlg[1] = (r == 8'h00);
    mFlg[2] = r[7];
    mReg[d] = r;
  endtask

  task automatic issue(input logic [2:0] op, input logic [4:0] a,
                       input logic [4:0] b, input logic [4:0] d);
    @(negedge clk);
    opCode = op; srcA = a; srcB = b; dstIdx = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic checkAllZero(input string tag);
    logic [7:0] v;
    for (int i = 0; i < 32; i++) begin
      peek(5'(i), v);
      chk(tag, {8'h00, v}, 16'h0000);
    end
    chk(tag, {11'd0, flags}, 16'h0000);
  endtask

  task automatic mulTest(input logic [4:0] a, input logic [4:0] b, input logic ignoreTry);
    logic [15:0] p;
    logic [7:0] v0, v1, v20;
    p = mReg[a] * mReg[b];
    @(negedge clk);
    opCode = 3'd6; srcA = a; srcB = b; dstIdx = 5'd30; start = 1'b1;
    @(negedge clk);
    chk("R8 busy after multiply start", {15'd0, busy}, 16'd1);
    peek(5'd0, v0);
    chk("R7 no write at start edge", {8'h00, v0}, {8'h00, mReg[0]});
    if (ignoreTry) begin
      opCode = 3'd0; srcA = 5'd3; srcB = 5'd3; dstIdx = 5'd20;  // R9 strobe while busy
    end else begin
      start = 1'b0;
    end
    @(negedge clk);
    start = 1'b0;
    mReg[0] = p[7:0];
    mReg[1] = p[15:8];
    mFlg[0] = p[15];
    mFlg[1] = (p == 16'h0000);
    chk("R8 busy drops", {15'd0, busy}, 16'd0);
    peek(5'd0, v0);
    peek(5'd1, v1);
    chk("R7 product pair", {v1, v0}, p);
    chk("R7 flags after multiply", {11'd0, flags}, {11'd0, mFlg});
    if (ignoreTry) begin
      peek(5'd20, v20);
      chk("R9 ignored strobe left dst alone", {8'h00, v20}, 16'h0000);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nBad++;
    nChk++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    logic [7:0] v, v2;
    logic [4:0] savedFlg;
    rst = 1'b1; start = 1'b0; opCode = 3'd0;
    srcA = '0; srcB = '0; dstIdx = '0; dbgIdx = '0;
    for (int i = 0; i < 32; i++) mReg[i] = 8'h00;
    mFlg = 5'd0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    checkAllZero("R1 reset state");
    chk("R8 idle busy", {15'd0, busy}, 16'd0);

    // table walk: R2 write-back, R3/R4/R5/R6 flags, R10 same-index chains
    for (int k = 0; k < NVEC; k++) begin
      logic [2:0] op;
      logic [4:0] a, b, d;
      logic [7:0] expRes;
      {op, a, b, d, expRes} = VEC[k];
      issue(op, a, b, d);
      modelOp(op, a, b, d);
      peek(d, v);
      chk("R2 R10 result", {8'h00, v}, {8'h00, expRes});
      chk("R3 R4 R5 R6 flags", {11'd0, flags}, {11'd0, mFlg});
    end

    // R10: increment in place, 0x7F -> 0x80
    issue(3'd2, 5'd12, 5'd0, 5'd12);
    modelOp(3'd2, 5'd12, 5'd0, 5'd12);
    peek(5'd12, v);
    chk("R10 in-place increment", {8'h00, v}, 16'h0080);
    chk("R5 increment overflow flags", {11'd0, flags}, {11'd0, mFlg});

    // R11: combinational debug read
    dbgIdx = 5'd2;
    #1;
    v = dbgData;
    dbgIdx = 5'd13;
    #1;
    v2 = dbgData;
    chk("R11 debug read A", {8'h00, v}, 16'h00FF);
    chk("R11 debug read B", {8'h00, v2}, 16'h0081);

    // R12: reserved opcode and idle strobe
    savedFlg = mFlg;
    issue(3'd7, 5'd2, 5'd2, 5'd3);
    peek(5'd3, v);
    chk("R12 reserved opcode no write", {8'h00, v}, {8'h00, mReg[3]});
    chk("R12 reserved opcode no flags", {11'd0, flags}, {11'd0, savedFlg});
    @(negedge clk);
    opCode = 3'd5; srcA = 5'd2; dstIdx = 5'd3; start = 1'b0;
    @(negedge clk);
    peek(5'd3, v);
    chk("R12 start low no write", {8'h00, v}, {8'h00, mReg[3]});

    // R7/R8/R9: multiplies
    mulTest(5'd6, 5'd2, 1'b1);   // 0x80*0xFF = 0x7F80, strobe during busy
    mulTest(5'd2, 5'd2, 1'b0);   // 0xFF*0xFF = 0xFE01, C set
    mulTest(5'd9, 5'd2, 1'b0);   // zero product, Z set
    @(negedge clk);
    chk("R8 busy stays low", {15'd0, busy}, 16'd0);

    // R1: reset with populated file
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 32; i++) mReg[i] = 8'h00;
    mFlg = 5'd0;
    @(negedge clk);
    checkAllZero("R1 reset after activity");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

endmodule